// File: doc/BRIEF.md
# Boot-Window Command Sequencer

This block watches word writes aimed at the two boot-buffer address windows of a paged flash device and treats each such write as a short command. It handles three: a warm reset request, an identification readout that fills the first three boot-buffer words, and a two-write page load. For a page load it turns the block and page address registers into a 512-byte sector number and issues a one-cycle load request for a full 2 KB page (four sectors). It then steps the page register forward by one page.

The block register, the identification values and the write-protection status come in as inputs. The page register lives inside the block. The host can set it through a direct write port, and it is exposed on an output. Five states drive the control: `S_IDLE` waits for a command. `S_ARMED` waits for the data write of a page load. `S_ID_MAN`, `S_ID_DEV` and `S_ID_WP` each put out one identification word.

The transitions are as follows:
- `S_IDLE` goes to `S_ARMED` on 0x00E0 and to `S_ID_MAN` on 0x0090.
- `S_ARMED` returns to `S_IDLE` on any window write, and raises a load first if the value is zero.
- `S_ID_MAN` goes to `S_ID_DEV`, `S_ID_DEV` goes to `S_ID_WP`, and `S_ID_WP` goes back to `S_IDLE`. Each of these steps takes one cycle.
- 0x00F0 in `S_IDLE` requests a reset and stays in `S_IDLE`.

Top module: `boot_cmd_seq`

## Requirements
- R1: Only writes to word addresses 0x0000–0x01FF or 0x8000–0x800F are treated as commands. A write anywhere else changes no state and raises no output.
- R2: In `S_IDLE`, a window write of 0x00F0 raises `rst_req` for exactly one cycle, starting the cycle after the write, and clears the page register to 0.
- R3: In `S_IDLE`, a window write of 0x00E0 arms the sequencer. If the next window write has the value 0x0000, `load_req` pulses for one cycle, starting the cycle after that write, with `load_cnt` = 4.
- R4: If the window write that follows an arming write is not 0x0000, the sequencer disarms without loading. A later 0x0000 write then starts nothing.
- R5: `load_sec` = (page & 3) + ((((page >> 2) & 0x3F) + (field << 6)) << 2). Here `field` is the low 12 bits of `blk_addr`, and the page value is the one in effect before the load.
- R6: When `blk_addr[15]` is set and `dev_id[3]` is set, `field` also has the density mask ORed in. The mask is 1 << (6 + `dev_id[6:4]`). When `dev_id[3]` is clear, the mask is 0.
- R7: A page load advances the page register by 4, modulo 256. This update takes precedence over a direct page write in the same cycle.
- R8: In `S_IDLE`, a window write of 0x0090 causes three consecutive cycles of `id_we`, starting the cycle after the write. The word index runs 0, 1, 2. The data is, in order, the low byte of `man_id`, the low byte of `dev_id` and the low byte of `wp_stat`, each with the upper byte zero.
- R9: In `S_IDLE`, any window value other than 0x00F0, 0x00E0 and 0x0090 is ignored.
- R10: Window writes that arrive while identification words are being output are ignored.
- R11: Hardware reset leaves the block in `S_IDLE` with the page register at 0 and all requests low, and it cancels an armed load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Word write strobe |
| wr_addr | input | 16 | Word address of the write |
| wr_data | input | 16 | Write value |
| blk_addr | input | 16 | Block address register (bit 15 selects the high-density half) |
| pg_we | input | 1 | Direct write of the page register |
| pg_wdata | input | 8 | Value for the direct page write |
| man_id | input | 16 | Manufacturer identification |
| dev_id | input | 16 | Device identification (bit 3 and bits 6:4 set the density mask) |
| wp_stat | input | 16 | Write-protection status |
| page_q | output | 8 | Current page register |
| rst_req | output | 1 | One-cycle warm reset request |
| id_we | output | 1 | Boot-buffer identification word write |
| id_idx | output | 2 | Boot-buffer word index for `id_we` |
| id_wdata | output | 16 | Identification word value |
| load_req | output | 1 | One-cycle page load request |
| load_sec | output | 22 | Starting sector of the load |
| load_cnt | output | 3 | Sectors to load (always 4) |

## Verification
The bench probes the window edges at 0x01FF, 0x0200, 0x800F and 0x8010. A decoder with an off-by-one boundary would accept or drop a command at one of these addresses. It arms the sequencer and then writes a nonzero value, followed by a zero. A design that left the flag set would load on that zero. It loads from page 0xFC with a high-density block to check both the wrap of the page register to 0x00 and the effect of the mask on the sector number. A missing mask or an unmasked page would give the wrong sector or a page of 0x100. It also issues a reset command while identification words are being output, and asserts hardware reset while the sequencer is armed. A design that decoded writes in those states, or kept the armed flag through reset, would pulse `rst_req` or `load_req` when it should not.

// File: rtl/boot_cmd_pkg.sv
package boot_cmd_pkg;
    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_ARMED  = 3'd1,
        S_ID_MAN = 3'd2,
        S_ID_DEV = 3'd3,
        S_ID_WP  = 3'd4
    } seq_state_t;

    localparam logic [15:0] CMD_WARM_RST = 16'h00F0;
    localparam logic [15:0] CMD_ARM_LOAD = 16'h00E0;
    localparam logic [15:0] CMD_READ_ID  = 16'h0090;
    localparam logic [15:0] LOAD_DATA    = 16'h0000;
endpackage

// File: rtl/boot_win_dec.sv
module boot_win_dec #(
    parameter int          AW      = 16,
    parameter logic [15:0] LO_BASE = 16'h0000,
    parameter logic [15:0] LO_LAST = 16'h01FF,
    parameter logic [15:0] HI_BASE = 16'h8000,
    parameter logic [15:0] HI_LAST = 16'h800F
) (
    input  logic [AW-1:0] addr,
    output logic          hit
);
    localparam int NWIN = 2;
    logic [NWIN-1:0] in_win;
    logic [15:0]     base_tab [NWIN];
    logic [15:0]     last_tab [NWIN];

    assign base_tab[0] = LO_BASE;
    assign last_tab[0] = LO_LAST;
    assign base_tab[1] = HI_BASE;
    assign last_tab[1] = HI_LAST;

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        assign in_win[w] = (addr >= AW'(base_tab[w])) && (addr <= AW'(last_tab[w]));
    end

    assign hit = |in_win;
endmodule

// File: rtl/sector_calc.sv
module sector_calc #(
    parameter int BLK_W   = 12,
    parameter int PAGE_W  = 8,
    parameter int FIELD_W = BLK_W + 2,
    parameter int SEC_W   = FIELD_W + PAGE_W
) (
    input  logic [15:0]       blk_addr,
    input  logic [15:0]       dev_id,
    input  logic [PAGE_W-1:0] page,
    output logic [SEC_W-1:0]  sector
);
    logic [FIELD_W-1:0] dmask;
    logic [FIELD_W-1:0] field;
    logic [3:0]         mshift;

    assign mshift = 4'd6 + {1'b0, dev_id[6:4]};
    assign dmask  = dev_id[3] ? (FIELD_W'(1) << mshift) : '0;
    assign field  = FIELD_W'(blk_addr[BLK_W-1:0]) | (blk_addr[15] ? dmask : '0);

    assign sector = SEC_W'(page[1:0])
                  + ((SEC_W'(page[PAGE_W-1:2]) + (SEC_W'(field) << 6)) << 2);
endmodule

// File: rtl/boot_cmd_seq.sv
module boot_cmd_seq
    import boot_cmd_pkg::*;
#(
    parameter int AW      = 16,
    parameter int DW      = 16,
    parameter int BLK_W   = 12,
    parameter int PAGE_W  = 8,
    parameter int SEC_PER_PAGE = 4,
    localparam int FIELD_W = BLK_W + 2,
    localparam int SEC_W   = FIELD_W + PAGE_W,
    localparam int CNT_W   = $clog2(SEC_PER_PAGE + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [15:0]       blk_addr,
    input  logic              pg_we,
    input  logic [PAGE_W-1:0] pg_wdata,
    input  logic [15:0]       man_id,
    input  logic [15:0]       dev_id,
    input  logic [15:0]       wp_stat,
    output logic [PAGE_W-1:0] page_q,
    output logic              rst_req,
    output logic              id_we,
    output logic [1:0]        id_idx,
    output logic [DW-1:0]     id_wdata,
    output logic              load_req,
    output logic [SEC_W-1:0]  load_sec,
    output logic [CNT_W-1:0]  load_cnt
);
    seq_state_t       state_q, state_d;
    logic             win_hit;
    logic             cmd_wr;
    logic             do_load, do_rst;
    logic [SEC_W-1:0] sec_now;

    boot_win_dec #(.AW(AW)) u_dec (
        .addr (wr_addr),
        .hit  (win_hit)
    );

    sector_calc #(.BLK_W(BLK_W), .PAGE_W(PAGE_W)) u_sec (
        .blk_addr (blk_addr),
        .dev_id   (dev_id),
        .page     (page_q),
        .sector   (sec_now)
    );

    assign cmd_wr = wr_en && win_hit;

    // next state and the two pulse decisions
    always_comb begin
        state_d = state_q;
        do_load = 1'b0;
        do_rst  = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (cmd_wr) begin
                    if (wr_data == DW'(CMD_ARM_LOAD))      state_d = S_ARMED;
                    else if (wr_data == DW'(CMD_READ_ID))  state_d = S_ID_MAN;
                    else if (wr_data == DW'(CMD_WARM_RST)) do_rst  = 1'b1;
                end
            end
            S_ARMED: begin
                if (cmd_wr) begin
                    state_d = S_IDLE;
                    do_load = (wr_data == DW'(LOAD_DATA));
                end
            end
            S_ID_MAN: state_d = S_ID_DEV;
            S_ID_DEV: state_d = S_ID_WP;
            S_ID_WP:  state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // state register and page register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            page_q   <= '0;
            rst_req  <= 1'b0;
            load_req <= 1'b0;
            load_sec <= '0;
        end else begin
            state_q  <= state_d;
            rst_req  <= do_rst;
            load_req <= do_load;
            if (do_load) begin
                load_sec <= sec_now;
                page_q   <= page_q + PAGE_W'(SEC_PER_PAGE);
            end else if (do_rst) begin
                page_q   <= '0;
            end else if (pg_we) begin
                page_q   <= pg_wdata;
            end
        end
    end

    // identification word outputs
    always_comb begin
        id_we    = 1'b0;
        id_idx   = 2'd0;
        id_wdata = '0;
        unique case (state_q)
            S_ID_MAN: begin id_we = 1'b1; id_idx = 2'd0; id_wdata = DW'(man_id[7:0]);  end
            S_ID_DEV: begin id_we = 1'b1; id_idx = 2'd1; id_wdata = DW'(dev_id[7:0]);  end
            S_ID_WP:  begin id_we = 1'b1; id_idx = 2'd2; id_wdata = DW'(wp_stat[7:0]); end
            default:  ;
        endcase
    end

    assign load_cnt = CNT_W'(SEC_PER_PAGE);
endmodule

// File: rtl/boot_cmd_seq_chk.sv
module boot_cmd_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] page_q,
    input logic       rst_req,
    input logic       id_we,
    input logic [1:0] id_idx,
    input logic       load_req,
    input logic [2:0] load_cnt
);
    // R7
    page_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_req |-> page_q == 8'($past(page_q) + 8'd4));

    // R2
    rst_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> page_q == 8'd0);

    // R2
    rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R3
    load_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_req |=> !load_req);

    // R3
    load_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_req |-> load_cnt == 3'd4);

    // R8
    id_seq0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (id_we && id_idx == 2'd0) |=> (id_we && id_idx == 2'd1));

    // R8
    id_seq1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (id_we && id_idx == 2'd1) |=> (id_we && id_idx == 2'd2));

    // R10
    id_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({id_we, load_req, rst_req}));
endmodule

bind boot_cmd_seq boot_cmd_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .page_q   (page_q),
    .rst_req  (rst_req),
    .id_we    (id_we),
    .id_idx   (id_idx),
    .load_req (load_req),
    .load_cnt (load_cnt)
);

// File: tb/sim_boot_cmd_seq.sv
module sim_boot_cmd_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] blk_addr = '0;
    logic        pg_we = 1'b0;
    logic [7:0]  pg_wdata = '0;
    logic [15:0] man_id = 16'hA1EC;
    logic [15:0] dev_id = 16'h0000;
    logic [15:0] wp_stat = 16'h0402;
    logic [7:0]  page_q;
    logic        rst_req, id_we, load_req;
    logic [1:0]  id_idx;
    logic [15:0] id_wdata;
    logic [21:0] load_sec;
    logic [2:0]  load_cnt;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    boot_cmd_seq u0 (.*);

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic longint model_sec(input logic [15:0] blk, input logic [15:0] dev,
                                         input logic [7:0] pg);
        longint m, f;
        m = dev[3] ? (longint'(1) << (6 + dev[6:4])) : 0;
        f = longint'(blk[11:0]) | (blk[15] ? m : 0);
        return longint'(pg & 3) + (((longint'(pg >> 2) & 'h3F) + (f << 6)) << 2);
    endfunction

    // called at a falling edge, returns at the next falling edge
    task automatic wr(input logic [15:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_page(input logic [7:0] p);
        pg_we = 1'b1; pg_wdata = p;
        @(negedge clk);
        pg_we = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        do_reset();
        chk("R11 page", page_q, 0);
        chk("R11 rst_req", rst_req, 0);
        chk("R11 load_req", load_req, 0);
        chk("R11 id_we", id_we, 0);
    endtask

    task automatic t_load_basic();
        blk_addr = 16'h0005; dev_id = 16'h0000;
        set_page(8'h09);
        wr(16'h0000, 16'h00E0);
        chk("R3 no load on arm", load_req, 0);
        wr(16'h0100, 16'h0000);
        chk("R3 load_req", load_req, 1);
        chk("R3 load_cnt", load_cnt, 4);
        chk("R5 sector", load_sec, model_sec(16'h0005, 16'h0000, 8'h09));
        chk("R7 page+4", page_q, 8'h0D);
        @(negedge clk);
        chk("R3 pulse one cycle", load_req, 0);
    endtask

    task automatic t_load_density_wrap();
        blk_addr = 16'h8003; dev_id = 16'h0028;
        set_page(8'hFC);
        wr(16'h8000, 16'h00E0);
        wr(16'h800F, 16'h0000);
        chk("R6 sector with mask", load_sec, model_sec(16'h8003, 16'h0028, 8'hFC));
        chk("R6 mask value", load_sec, 66556);
        chk("R7 page wrap", page_q, 8'h00);
        @(negedge clk);
        dev_id = 16'h0020; blk_addr = 16'h8003;
        set_page(8'h01);
        wr(16'h0000, 16'h00E0);
        wr(16'h0000, 16'h0000);
        chk("R6 no mask when bit3 clear", load_sec, model_sec(16'h8003, 16'h0020, 8'h01));
        @(negedge clk);
    endtask

    task automatic t_disarm();
        blk_addr = 16'h0001; dev_id = 16'h0000;
        set_page(8'h10);
        wr(16'h0000, 16'h00E0);
        wr(16'h0000, 16'h0001);
        chk("R4 no load on nonzero", load_req, 0);
        wr(16'h0000, 16'h0000);
        chk("R4 zero after disarm", load_req, 0);
        chk("R4 page kept", page_q, 8'h10);
    endtask

    task automatic t_window_edges();
        set_page(8'h20);
        wr(16'h0200, 16'h00E0);
        wr(16'h0000, 16'h0000);
        chk("R1 0x0200 ignored", load_req, 0);
        wr(16'h8010, 16'h00F0);
        chk("R1 0x8010 ignored", rst_req, 0);
        wr(16'h01FF, 16'h00E0);
        wr(16'h800F, 16'h0000);
        chk("R1 edges decoded", load_req, 1);
        chk("R1 page moved", page_q, 8'h24);
        @(negedge clk);
    endtask

    task automatic t_warm_reset();
        set_page(8'h44);
        wr(16'h0010, 16'h00F0);
        chk("R2 rst_req", rst_req, 1);
        chk("R2 page cleared", page_q, 0);
        @(negedge clk);
        chk("R2 pulse one cycle", rst_req, 0);
    endtask

    task automatic t_ignore();
        set_page(8'h30);
        wr(16'h0000, 16'h0077);
        chk("R9 no rst", rst_req, 0);
        chk("R9 no id", id_we, 0);
        wr(16'h0000, 16'h0000);
        chk("R9 not armed", load_req, 0);
        chk("R9 page kept", page_q, 8'h30);
    endtask

    task automatic t_id();
        dev_id = 16'h1234;
        wr(16'h8004, 16'h0090);
        chk("R8 we0", id_we, 1);
        chk("R8 idx0", id_idx, 0);
        chk("R8 man", id_wdata, 16'h00EC);
        wr(16'h0000, 16'h00F0);
        chk("R10 reset ignored", rst_req, 0);
        chk("R8 idx1", id_idx, 1);
        chk("R8 dev", id_wdata, 16'h0034);
        @(negedge clk);
        chk("R8 idx2", id_idx, 2);
        chk("R8 wp", id_wdata, 16'h0002);
        @(negedge clk);
        chk("R8 done", id_we, 0);
        chk("R10 still no reset", rst_req, 0);
    endtask

    task automatic t_reset_clears_arm();
        wr(16'h0000, 16'h00E0);
        do_reset();
        wr(16'h0000, 16'h0000);
        chk("R11 arm cancelled", load_req, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset_state();
        t_load_basic();
        t_load_density_wrap();
        t_disarm();
        t_window_edges();
        t_warm_reset();
        t_ignore();
        t_id();
        t_reset_clears_arm();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule